// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small word-addressed register port. A down-counter, paced by the block clock, reloads from a programmed interval. The first time it runs out, the block raises an interrupt. If software has not cleared that interrupt by the next time the counter runs out, and resets are enabled, the block asserts a system reset that stays on until the block itself is reset. Software services the watchdog by writing any value to the service register. That write clears the pending interrupt and restarts the interval.

Every register except the lock is write-protected by a key. The block comes out of reset locked. Writing the key to the lock register opens it, and writing any other value closes it again. Reading the lock register returns the live lock state, so software can confirm that its earlier writes have landed. The full timeout spans two intervals, so software programs the load value as half the required clock count minus one. Requested intervals below a minimum are raised to that minimum.

The sequencing is held in a three-state machine:
- `ST_IDLE`: the counter is halted.
- `ST_RUN`: the counter is counting.
- `ST_BITE`: the reset is asserted. This state is terminal.

The transitions are:
- `GO`: `ST_IDLE` to `ST_RUN`, when the run bit is set.
- `HALT`: `ST_RUN` to `ST_IDLE`, when the run bit is cleared.
- `BITE`: `ST_RUN` to `ST_BITE`, on an expiry with the interrupt pending and reset enabled.

The machine follows the registered control bits, so counting starts and stops one clock after the control write.

Top module: `wdog_top`

## Requirements
- R1: After reset, the lock register reads 1, the load register reads 32'hFFFFFFFF, the control register reads 0, the raw status reads 0, and `irq_o` and `sys_rst_o` are both 0.
- R2: Writing 32'h1ACCE551 to the lock register (word 6) makes it read 0. Writing any other value makes it read 1. While the lock reads 1, writes to every other register have no effect.
- R3: Control (word 2) has bit 0 as run/interrupt enable and bit 1 as reset enable. The counter decrements once per clock from the second clock edge after bit 0 is written 1. After bit 0 is written 0, the count stops changing from the second edge on.
- R4: The value register (word 1) returns the live count. While running, a count of 0 reloads from the load register on the next edge, so expiries occur every load+1 clocks.
- R5: An expiry sets raw status bit 0 (word 4). Masked status (word 5) and `irq_o` equal raw status ANDed with control bit 0.
- R6: Any unlocked write to the service register (word 3) clears the raw status and reloads the counter from the load register on that edge.
- R7: An expiry while raw status is already 1 and control bit 1 is 1 asserts `sys_rst_o`. It stays 1 until `rst_n` goes low, and the count stops changing.
- R8: An expiry while raw status is 1 and control bit 1 is 0 leaves `sys_rst_o` at 0, keeps the interrupt pending and keeps counting.
- R9: An unlocked write to the load register (word 0) stores the data, raised to at least LOAD_MIN, and loads the counter with that value on the same edge.
- R10: Reads of the service register and of the unused word 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also paces the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt, the masked status |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with LOAD_MIN set to 6 and keeps the default all-ones reset load. A small minimum lets a load of 3 show the clamp. Loads of 10 give eleven-clock intervals, so first expiry, second expiry, the masked and unmasked status, the serviced path and the reset path all fall within a few hundred clocks. The behavioural model predicts the read data at whatever address is presented, so the live count, status and lock are compared on every clock, including the one-clock lag of the run bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W = 3;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [SEL_W-1:0] {
        REG_LOAD   = 3'd0,
        REG_VALUE  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_SVC    = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_LOCK   = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_BITE = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic rst_en;
        logic run_en;
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          LOAD_MIN   = 16,
    parameter logic [31:0] RESET_LOAD = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] load_new,
    output ctrl_t             ctrl_q,
    output logic              lock_q,
    output logic              load_wr,
    output logic              svc_wr
);

    localparam logic [DATA_W-1:0] MIN_V = DATA_W'(LOAD_MIN);
    localparam logic [DATA_W-1:0] KEY_V = DATA_W'(UNLOCK_KEY);

    reg_sel_e sel;
    logic     open_wr;
    logic     lock_wr;
    logic     ctrl_wr;

    assign sel     = reg_sel_e'(bus_addr);
    assign open_wr = bus_we && !lock_q;
    assign lock_wr = bus_we && (sel == REG_LOCK);
    assign load_wr = open_wr && (sel == REG_LOAD);
    assign ctrl_wr = open_wr && (sel == REG_CTRL);
    assign svc_wr  = open_wr && (sel == REG_SVC);

    // raise small requests to the minimum interval
    assign load_new = (bus_wdata < MIN_V) ? MIN_V : bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
        end else if (lock_wr) begin
            lock_q <= (bus_wdata != KEY_V);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= DATA_W'(RESET_LOAD);
        end else if (load_wr) begin
            load_q <= load_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run_en <= bus_wdata[0];
            ctrl_q.rst_en <= bus_wdata[1];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_LOAD:   bus_rdata = load_q;
            REG_VALUE:  bus_rdata = count;
            REG_CTRL:   bus_rdata[1:0] = {ctrl_q.rst_en, ctrl_q.run_en};
            REG_SVC:    bus_rdata = '0;
            REG_RAW:    bus_rdata[0] = raw;
            REG_MASKED: bus_rdata[0] = raw & ctrl_q.run_en;
            REG_LOCK:   bus_rdata[0] = lock_q;
            REG_NONE:   bus_rdata = '0;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] RESET_LOAD = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_new,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] count,
    output logic              expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = run && !load_wr && !svc_wr && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= DATA_W'(RESET_LOAD);
        end else if (load_wr) begin
            count <= load_new;
        end else if (svc_wr) begin
            count <= load_q;
        end else if (run) begin
            count <= at_zero ? load_q : count - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctrl_t     ctrl_q,
    input  logic      expire,
    input  logic      svc_wr,
    output wd_state_e state_q,
    output logic      raw_q,
    output logic      irq_o,
    output logic      sys_rst_o
);

    wd_state_e state_d;
    logic      bite;

    assign bite = expire && raw_q && ctrl_q.rst_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_q.run_en) state_d = ST_RUN;      // GO
            ST_RUN: begin
                if (bite)                state_d = ST_BITE;    // BITE
                else if (!ctrl_q.run_en) state_d = ST_IDLE;    // HALT
            end
            ST_BITE: state_d = ST_BITE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (svc_wr) raw_q <= 1'b0;
        else if (expire) raw_q <= 1'b1;
    end

    always_comb begin
        irq_o     = raw_q & ctrl_q.run_en;
        sys_rst_o = (state_q == ST_BITE);
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          LOAD_MIN   = 16,
    parameter logic [31:0] RESET_LOAD = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] load_new;
    logic [DATA_W-1:0] count;
    ctrl_t             ctrl_q;
    logic              lock_q;
    logic              load_wr;
    logic              svc_wr;
    logic              expire;
    logic              raw_q;
    wd_state_e         state_q;

    wdog_regs #(
        .DATA_W(DATA_W), .LOAD_MIN(LOAD_MIN), .RESET_LOAD(RESET_LOAD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
        .raw(raw_q), .load_q(load_q), .load_new(load_new), .ctrl_q(ctrl_q),
        .lock_q(lock_q), .load_wr(load_wr), .svc_wr(svc_wr)
    );

    wdog_counter #(
        .DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN),
        .load_wr(load_wr), .load_new(load_new), .svc_wr(svc_wr),
        .load_q(load_q), .count(count), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .expire(expire),
        .svc_wr(svc_wr), .state_q(state_q), .raw_q(raw_q),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LOAD_MIN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_we,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] count,
    input ctrl_t             ctrl_q,
    input logic              lock_q,
    input logic              raw_q,
    input wd_state_e         state_q
);

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && bus_we && bus_addr != REG_LOCK) |=> ($stable(load_q) && $stable(ctrl_q))); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && count != '0 && !bus_we) |=> (count == $past(count) - 1'b1)); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.run_en); // R5

    AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && bus_we && bus_addr == REG_SVC) |=> !raw_q); // R6

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> sys_rst_o); // R7

    AST_BITE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(raw_q) && $past(ctrl_q.rst_en))); // R7

    AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        load_q >= DATA_W'(LOAD_MIN)); // R9

endmodule

bind wdog_top wdog_chk #(.DATA_W(DATA_W), .LOAD_MIN(LOAD_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o), .load_q(load_q), .count(count),
    .ctrl_q(ctrl_q), .lock_q(lock_q), .raw_q(raw_q), .state_q(state_q)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;

    localparam int MIN = 6;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd1;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    bit          m_lock;
    logic [31:0] m_load, m_cnt;
    bit          m_run_en, m_rst_en, m_raw, m_run, m_bite;

    always #2.5 clk = ~clk;

    wdog_top #(.LOAD_MIN(MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {30'd0, m_rst_en, m_run_en};
            3'd4: return {31'd0, m_raw};
            3'd5: return {31'd0, m_raw & m_run_en};
            3'd6: return {31'd0, m_lock};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 1; m_load = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF;
            m_run_en = 0; m_rst_en = 0; m_raw = 0; m_run = 0; m_bite = 0;
        end else begin
            bit ok, ldw, svc, exp, n_run, n_bite;
            logic [31:0] lv;
            ok  = bus_we && !m_lock;
            ldw = ok && bus_addr == 3'd0;
            svc = ok && bus_addr == 3'd3;
            lv  = (bus_wdata < MIN) ? MIN : bus_wdata;
            exp = m_run && !ldw && !svc && m_cnt == 0;
            n_bite = m_bite || (exp && m_raw && m_rst_en);
            n_run  = !n_bite && (m_run ? !(exp && m_raw && m_rst_en) && m_run_en : m_run_en);
            if (ldw) m_cnt = lv;
            else if (svc) m_cnt = m_load;
            else if (m_run) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
            if (svc) m_raw = 0; else if (exp) m_raw = 1;
            if (ldw) m_load = lv;
            if (ok && bus_addr == 3'd2) begin m_run_en = bus_wdata[0]; m_rst_en = bus_wdata[1]; end
            if (bus_we && bus_addr == 3'd6) m_lock = (bus_wdata != KEY);
            m_run = n_run; m_bite = n_bite;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model (R4 live count, R5 status, R7 reset)
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R4/R10 cycle rdata", bus_rdata, m_read(bus_addr));
            check("R5 cycle irq", {31'd0, irq_o}, {31'd0, m_raw & m_run_en});
            check("R7 cycle sys_rst", {31'd0, sys_rst_o}, {31'd0, m_bite});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk); bus_we = 0; bus_addr = 3'd1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a;
        @(posedge clk); #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000ns;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v1;
        int waited;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd6, 32'd1, "R1 lock after reset");
        rd(3'd0, 32'hFFFFFFFF, "R1 load after reset");
        rd(3'd2, 32'd0, "R1 ctrl after reset");
        rd(3'd4, 32'd0, "R1 raw after reset");
        check("R1 irq/sys_rst after reset", {30'd0, irq_o, sys_rst_o}, 32'd0);
        // R2 locked writes ignored, bad key, good key
        wr(3'd0, 32'd20);
        rd(3'd0, 32'hFFFFFFFF, "R2 load write ignored while locked");
        wr(3'd6, 32'h12345678);
        rd(3'd6, 32'd1, "R2 wrong key keeps lock");
        wr(3'd6, KEY);
        rd(3'd6, 32'd0, "R2 key unlocks");
        // R9 clamp and immediate reload
        wr(3'd0, 32'd3);
        rd(3'd0, MIN, "R9 load clamped");
        rd(3'd1, MIN, "R9 counter reloaded");
        wr(3'd0, 32'd10);
        rd(3'd1, 32'd10, "R9 counter reloaded on write");
        // R3/R4/R5 first expiry with reset disabled
        wr(3'd2, 32'd1);
        waited = 0;
        for (int i = 0; i < 40 && !irq_o; i++) begin idle(1); waited++; end
        check("R5 irq raised at first expiry", {31'd0, irq_o}, 32'd1);
        rd(3'd4, 32'd1, "R5 raw status set");
        rd(3'd5, 32'd1, "R5 masked status set");
        // R6 service
        wr(3'd3, 32'hDEAD);
        rd(3'd4, 32'd0, "R6 raw cleared by service");
        check("R6 irq cleared", {31'd0, irq_o}, 32'd0);
        // R8 two expiries without reset enable
        idle(30);
        check("R8 no reset with reset disabled", {31'd0, sys_rst_o}, 32'd0);
        check("R8 irq still pending", {31'd0, irq_o}, 32'd1);
        // R3 halt; R5 masking
        wr(3'd2, 32'd0);
        idle(2);
        rd(3'd1, m_cnt, "R3 count after halt");
        v1 = bus_rdata;
        idle(5);
        rd(3'd1, v1, "R3 count holds while halted");
        rd(3'd4, 32'd1, "R5 raw kept while masked");
        rd(3'd5, 32'd0, "R5 masked status off");
        check("R5 irq masked", {31'd0, irq_o}, 32'd0);
        // R6/R7 serviced path: reset enabled but serviced in time
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd3);
        for (int k = 0; k < 12; k++) begin wr(3'd3, k); idle(5); end
        check("R6 serviced watchdog never bites", {31'd0, sys_rst_o}, 32'd0);
        // R2 relock then R7 unserviced path
        wr(3'd6, 32'd0);
        wr(3'd2, 32'd0);
        rd(3'd2, 32'd3, "R2 ctrl write ignored after relock");
        for (int i = 0; i < 60 && !sys_rst_o; i++) idle(1);
        check("R7 reset asserted after unserviced second expiry", {31'd0, sys_rst_o}, 32'd1);
        rd(3'd1, m_cnt, "R7 count at bite");
        v1 = bus_rdata;
        idle(20);
        check("R7 reset sticky", {31'd0, sys_rst_o}, 32'd1);
        rd(3'd1, v1, "R7 count frozen after bite");
        rd(3'd7, 32'd0, "R10 unused word reads 0");
        rd(3'd3, 32'd0, "R10 service word reads 0");
        @(negedge clk); rst_n = 0;
        idle(2);
        check("R7 reset cleared by block reset", {31'd0, sys_rst_o}, 32'd0);
        rst_n = 1;
        idle(2);
        finish_run();
    end

endmodule